// File: doc/BRIEF.md
# Prioritised Hardware Interrupt Controller

This block gathers a set of hardware interrupt request lines into a pending register and filters them through a per-line enable register. It picks the lowest-numbered line that is both pending and enabled. When the core's global interrupt-enable bit is set, it raises a request to the core. Along with the request it gives the winning line number, the software interrupt number assigned to that line, and the vector-table address where the handler pointer is stored.

The core drives a small command port with a bitmask. The command disables lines, enables lines, clears pending bits, or reads the pending register back. A separate wake output lets a core that is waiting for an interrupt resume. Wake ignores the global enable, so a core that waits with interrupts disabled still wakes up. Stacking state and fetching the handler pointer are the core's job.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending register is all zero, every line is disabled, and irq_req, wake and rd_data are 0.
- R2: A pending bit is set on the clock edge that sees its line at 1 when the line was 0 at the previous edge. A line that stays high does not set its bit again.
- R3: A pending bit stays set until an acknowledge command clears it.
- R4: The acknowledge command (cmd_op = 2'b10) clears the pending bits whose cmd_mask bit is 1. If a new rising edge reaches the same bit in the same cycle, that bit stays set.
- R5: The disable command (cmd_op = 2'b00) turns off each line whose cmd_mask bit is 1. The enable command (cmd_op = 2'b01) turns such lines on. Lines whose mask bit is 0 keep their setting.
- R6: irq_req is 1 exactly when int_enable is 1 and at least one line is both pending and enabled.
- R7: When irq_req is 1, irq_line is the lowest-numbered line that is pending and enabled. Line 0 has the highest priority.
- R8: irq_vector equals 0x70 plus irq_line. vector_addr equals 0xFF00 plus twice the low 7 bits of irq_vector.
- R9: While cmd_valid is 1 and cmd_op = 2'b11, rd_data shows the whole pending register, including pending bits of disabled lines. At all other times rd_data is 0. The read command changes no state.
- R10: wake is 1 exactly when at least one line is both pending and enabled, whatever the value of int_enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Hardware request lines, one per interrupt |
| int_enable | input | 1 | Global interrupt-enable bit from the core |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 disable, 01 enable, 10 acknowledge, 11 read |
| cmd_mask | input | 16 | Line bitmask for the command |
| rd_data | output | 16 | Pending register during a read command, else 0 |
| irq_req | output | 1 | Interrupt request to the core |
| irq_line | output | 4 | Winning line number |
| irq_vector | output | 8 | Software interrupt number of the winning line |
| vector_addr | output | 16 | Vector-table address of the handler pointer |
| wake | output | 1 | Resume signal for the wait state |

## Verification
First, each line is raised on its own. This separates a correct line-number and vector mapping from swapped or shifted bits. Second, every pair of lines is raised together. Each pair is checked once with both lines enabled and once with only the higher-numbered line enabled. This tells true lowest-number priority apart from plain pending order, and shows whether the enable filter is applied before the priority choice. Finally, held-high lines, acknowledges that meet a new edge in the same cycle, and requests with the global enable cleared separate edge detection from level detection, and wake from the request output.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N = 16,
  parameter logic [7:0] VEC_BASE = 8'h70,
  parameter logic [15:0] TABLE_BASE = 16'hFF00,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_lines,
  input  logic          int_enable,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [N-1:0]  cmd_mask,
  output logic [N-1:0]  rd_data,
  output logic          irq_req,
  output logic [IW-1:0] irq_line,
  output logic [7:0]    irq_vector,
  output logic [15:0]   vector_addr,
  output logic          wake
);
  localparam logic [1:0] OP_OFF = 2'b00, OP_ON = 2'b01, OP_ACK = 2'b10, OP_RD = 2'b11;

  logic [N-1:0] pending, enabled, prev;
  logic [N-1:0] rise, ack_bits, live;
  logic [IW-1:0] sel;

  assign rise     = irq_lines & ~prev;
  assign ack_bits = (cmd_valid && cmd_op == OP_ACK) ? cmd_mask : '0;
  assign live     = pending & enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      enabled <= '0;
      prev    <= '0;
    end else begin
      prev    <= irq_lines;
      pending <= (pending & ~ack_bits) | rise;
      if (cmd_valid && cmd_op == OP_OFF) enabled <= enabled & ~cmd_mask;
      else if (cmd_valid && cmd_op == OP_ON) enabled <= enabled | cmd_mask;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (live[i]) sel = IW'(i);
  end

  assign wake        = |live;
  assign irq_req     = int_enable && wake;
  assign irq_line    = sel;
  assign irq_vector  = VEC_BASE + 8'(sel);
  assign vector_addr = TABLE_BASE + {8'h00, irq_vector[6:0], 1'b0};
  assign rd_data     = (cmd_valid && cmd_op == OP_RD) ? pending : '0;

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & $past(rise)) == $past(rise)));

  assert_pending_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pending) & ~pending) & ~$past(ack_bits)) == '0));

  assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !int_enable |-> !irq_req);

  assert_winner_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pending[irq_line] && enabled[irq_line]));

  assert_wake_covers_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] irq_lines = '0, cmd_mask = '0;
  logic int_enable = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 2'b00;
  logic [15:0] rd_data, vector_addr;
  logic irq_req, wake;
  logic [3:0] irq_line;
  logic [7:0] irq_vector;

  int errors = 0, checks = 0;
  logic [15:0] m_pend = '0, m_en = '0, m_prev = '0;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mask(cmd_mask), .rd_data(rd_data),
    .irq_req(irq_req), .irq_line(irq_line), .irq_vector(irq_vector),
    .vector_addr(vector_addr), .wake(wake));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    logic [15:0] lv;
    int win;
    lv = m_pend & m_en;
    win = -1;
    for (int i = 15; i >= 0; i--) if (lv[i]) win = i;
    chk("R10 wake", 32'(wake), 32'(lv != 0));
    chk("R6 irq_req", 32'(irq_req), 32'(int_enable && lv != 0));
    if (win >= 0) begin
      chk("R7 irq_line", 32'(irq_line), 32'(win));
      chk("R8 irq_vector", 32'(irq_vector), 32'(8'h70 + win));
      chk("R8 vector_addr", 32'(vector_addr), 32'h0000FF00 + 32'(((8'h70 + win) & 8'h7F) * 2));
    end
  endtask

  task automatic step(logic [15:0] lines, logic ie, logic v, logic [1:0] op, logic [15:0] m);
    logic [15:0] rise;
    @(negedge clk);
    irq_lines = lines; int_enable = ie; cmd_valid = v; cmd_op = op; cmd_mask = m;
    #1;
    chk("R9 rd_data", 32'(rd_data), (v && op == 2'b11) ? 32'(m_pend) : 32'h0);
    @(posedge clk);
    rise = lines & ~m_prev;
    m_prev = lines;
    m_pend = (m_pend & ~((v && op == 2'b10) ? m : 16'h0)) | rise;
    if (v && op == 2'b00) m_en = m_en & ~m;
    if (v && op == 2'b01) m_en = m_en | m;
    #1;
    check_outs();
  endtask

  task automatic clear_all();
    step(16'h0, 0, 1, 2'b10, 16'hFFFF);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 reset wake", 32'(wake), 0);
    chk("R1 reset irq_req", 32'(irq_req), 0);
    chk("R1 reset rd_data", 32'(rd_data), 0);
    step(16'h0, 0, 1, 2'b11, 16'h0);
    chk("R1 reset pending", 32'(rd_data), 0);

    // R1/R5: lines start disabled; pending still visible by read (R9)
    step(16'h0021, 1, 0, 2'b00, 16'h0);
    chk("R1 disabled at reset", 32'(wake), 0);
    step(16'h0, 1, 1, 2'b11, 16'h0);
    step(16'h0, 1, 1, 2'b01, 16'hFFFF);
    chk("R5 enable shows pending", 32'(irq_line), 0);
    clear_all();

    // R7/R8: each line on its own
    for (int n = 0; n < 16; n++) begin
      step(16'(1 << n), 1, 0, 2'b00, 16'h0);
      step(16'h0, 1, 0, 2'b00, 16'h0);
      step(16'h0, 1, 1, 2'b11, 16'h0);
      clear_all();
    end

    // R7/R5: every pair, both enabled then only the higher one
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j++) begin
        step(16'((1 << i) | (1 << j)), 1, 0, 2'b00, 16'h0);
        step(16'h0, 1, 1, 2'b00, 16'(1 << i));
        step(16'h0, 0, 0, 2'b00, 16'h0);
        step(16'h0, 1, 1, 2'b01, 16'hFFFF);
        clear_all();
      end

    // R2: held line does not re-pend after ack
    step(16'h0100, 1, 0, 2'b00, 16'h0);
    step(16'h0100, 1, 1, 2'b10, 16'h0100);
    step(16'h0100, 1, 1, 2'b11, 16'h0);
    chk("R2 held level no repend", 32'(rd_data), 0);
    step(16'h0000, 1, 0, 2'b00, 16'h0);
    step(16'h0100, 1, 0, 2'b00, 16'h0);
    chk("R2 new edge pends", 32'(irq_line), 8);

    // R3: pending survives other commands
    step(16'h0000, 1, 1, 2'b10, 16'hFEFF);
    step(16'h0000, 1, 1, 2'b00, 16'h0100);
    step(16'h0000, 1, 1, 2'b01, 16'h0100);
    chk("R3 pending held", 32'(irq_line), 8);

    // R4: ack and new edge in the same cycle
    step(16'h0000, 1, 1, 2'b10, 16'hFFFF);
    step(16'h0040, 1, 1, 2'b10, 16'h0040);
    chk("R4 edge beats ack", 32'(irq_line), 6);
    step(16'h0040, 1, 1, 2'b10, 16'h0040);
    chk("R4 ack clears", 32'(wake), 0);

    // R10/R6: wake without global enable
    step(16'h8000, 0, 0, 2'b00, 16'h0);
    chk("R10 wake ie=0", 32'(wake), 1);
    chk("R6 no req ie=0", 32'(irq_req), 0);
    step(16'h8000, 1, 0, 2'b00, 16'h0);
    chk("R8 line15 addr", 32'(vector_addr), 32'hFFFE);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule